// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Scrambler and Descrambler

This block holds a transmit scrambler and a receive descrambler that share one shift-register design. Each side works one bit per cycle. Two runtime inputs choose the feedback polynomial and the scrambling mode, and both sides use the same setting. In self-synchronizing mode, the register is fed with the line bit: the transmitter feeds the bit it sends, and the receiver feeds the bit it gets. A receiver that starts from any state therefore falls into step once the register has filled with line bits. In synchronous mode, the register runs on its own feedback, and its output is XORed onto the data. Each side has a frame-start input that reloads the register, so both ends start every frame from the same point.

Output is combinational: the result for a bit appears in the same cycle the bit is presented. The register moves only on valid cycles. Changing the polynomial or the mode reloads both registers at once. Typical use is to scramble a serial payload before a line driver and to descramble it after bit recovery. Framing and deserialization are handled elsewhere.

Top module: `scr_pair`

## Requirements
- R1: After reset, both registers hold the seed, which is all ones. The selected configuration is then polynomial 0 in self-synchronizing mode, so a zero data stream gives zero output for the first six valid bits and a one on the seventh.
- R2: When `poly_sel_i` is 0, feedback is x^7+x^6+1, taken from register bits 6 and 5. When it is 1, feedback is x^23+x^18+1, taken from bits 22 and 17. Bit 0 receives the newest input.
- R3: When `mode_i` is 0 (self-synchronizing), the output bit is the input bit XOR the two tap bits. The transmit register shifts in the line bit it produced, and the receive register shifts in the line bit it received.
- R4: In self-synchronizing mode with the line looped back unchanged, the receive output equals the transmit data for every bit, under both polynomials.
- R5: In self-synchronizing mode, one flipped line bit at position k corrupts exactly three receive bits. These are at k, k+6 and k+7 for polynomial 0, and at k, k+18 and k+23 for polynomial 1.
- R6: When `mode_i` is 1 (synchronous), the register ignores the data and shifts in its own feedback. One flipped line bit then corrupts exactly one receive bit.
- R7: In synchronous mode, a valid bit that carries frame-start is scrambled with the seed state. Every frame therefore begins with the same keystream on both sides.
- R8: In self-synchronizing mode, the frame-start inputs have no effect on either output.
- R9: A change of `poly_sel_i` or `mode_i` makes both sides treat their register as the seed from that cycle on.
- R10: The register does not change on cycles without valid. Each output valid equals its input valid, and the result has zero cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poly_sel_i | input | 1 | Polynomial: 0 selects x^7+x^6+1, 1 selects x^23+x^18+1 |
| mode_i | input | 1 | 0 selects self-synchronizing, 1 selects synchronous |
| tx_valid_i | input | 1 | Transmit bit valid |
| tx_data_i | input | 1 | Transmit data bit |
| tx_frame_i | input | 1 | Transmit frame start (synchronous mode) |
| tx_valid_o | output | 1 | Line bit valid |
| tx_line_o | output | 1 | Scrambled line bit |
| rx_valid_i | input | 1 | Received line bit valid |
| rx_line_i | input | 1 | Received line bit |
| rx_frame_i | input | 1 | Receive frame start (synchronous mode) |
| rx_valid_o | output | 1 | Descrambled bit valid |
| rx_data_o | output | 1 | Descrambled data bit |

## Verification
The loopback is driven with four data patterns: all zeros, all ones, alternating bits and an irregular pattern. The zero stream shows the raw keystream and the seed behaviour. The all-ones and alternating streams show whether data and feedback are combined correctly. The irregular stream is there to catch a wrong tap.

A single flipped line bit separates the two modes. It should leave three errors at the tap distances in self-synchronizing mode and exactly one in synchronous mode. Repeated frame starts and configuration changes should reproduce an identical keystream. Gaps in valid show whether the register is held while no bit is presented.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned LFSR_W  = 23;
  localparam int unsigned TAP7_A  = 6;
  localparam int unsigned TAP7_B  = 5;
  localparam int unsigned TAP23_A = 22;
  localparam int unsigned TAP23_B = 17;
  localparam logic [LFSR_W-1:0] SEED = '1;

  typedef enum logic {POLY_X7 = 1'b0, POLY_X23 = 1'b1} poly_e;
  typedef enum logic {MODE_MULT = 1'b0, MODE_ADD = 1'b1} mode_e;

  typedef struct packed {
    poly_e poly;
    mode_e mode;
  } cfg_t;

  localparam cfg_t CFG_RST = '{poly: POLY_X7, mode: MODE_MULT};

  function automatic logic fb_of(input logic [LFSR_W-1:0] s, input poly_e p);
    logic f;
    case (p)
      POLY_X23: f = s[TAP23_A] ^ s[TAP23_B];
      default:  f = s[TAP7_A] ^ s[TAP7_B];
    endcase
    return f;
  endfunction
endpackage

// File: rtl/scr_cfg_watch.sv
module scr_cfg_watch
  import scr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output logic chg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_i;
  end

  assign chg_o = (cfg_i != cfg_q);

  // R9
  chg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o |=> (chg_o == (cfg_i != $past(cfg_i))));
endmodule

// File: rtl/scr_core.sv
module scr_core
  import scr_pkg::*;
#(
  parameter bit DESCR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic reseed_i,
  input  logic valid_i,
  input  logic bit_i,
  input  logic frame_i,
  output logic bit_o
);
  localparam int unsigned W = LFSR_W;

  logic [W-1:0] state_q, eff;
  logic fb, line_bit, feed_bit, reload;

  // frame start only reloads in synchronous mode
  assign reload   = reseed_i || (cfg_i.mode == MODE_ADD && frame_i);
  assign eff      = reload ? SEED : state_q;
  assign fb       = fb_of(eff, cfg_i.poly);
  assign bit_o    = bit_i ^ fb;

  generate
    if (DESCR) begin : g_rx
      assign line_bit = bit_i;
    end else begin : g_tx
      assign line_bit = bit_o;
    end
  endgenerate

  assign feed_bit = (cfg_i.mode == MODE_ADD) ? fb : line_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= SEED;
    else if (valid_i)  state_q <= {eff[W-2:0], feed_bit};
    else if (reseed_i) state_q <= SEED;
  end

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !reseed_i) |=> $stable(state_q));

  // R3
  mult_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.mode == MODE_MULT) |=> (state_q[0] == $past(line_bit)));

  // R6
  add_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.mode == MODE_ADD && !frame_i && !reseed_i)
      |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R7
  frame_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.mode == MODE_ADD && frame_i) |=> (state_q[W-1:1] == SEED[W-2:0]));

  // R2
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.mode == MODE_ADD)
      |-> ((cfg_i.poly == POLY_X7) ? (|eff[TAP7_A:0]) : (|eff)));
endmodule

// File: rtl/scr_pair.sv
module scr_pair
  import scr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poly_sel_i,
  input  logic mode_i,
  input  logic tx_valid_i,
  input  logic tx_data_i,
  input  logic tx_frame_i,
  output logic tx_valid_o,
  output logic tx_line_o,
  input  logic rx_valid_i,
  input  logic rx_line_i,
  input  logic rx_frame_i,
  output logic rx_valid_o,
  output logic rx_data_o
);
  cfg_t cfg;
  logic chg;

  assign cfg = '{poly: poly_e'(poly_sel_i), mode: mode_e'(mode_i)};

  scr_cfg_watch u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .chg_o  (chg)
  );

  scr_core #(.DESCR(1'b0)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .reseed_i (chg),
    .valid_i  (tx_valid_i),
    .bit_i    (tx_data_i),
    .frame_i  (tx_frame_i),
    .bit_o    (tx_line_o)
  );

  scr_core #(.DESCR(1'b1)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .reseed_i (chg),
    .valid_i  (rx_valid_i),
    .bit_i    (rx_line_i),
    .frame_i  (rx_frame_i),
    .bit_o    (rx_data_o)
  );

  assign tx_valid_o = tx_valid_i;
  assign rx_valid_o = rx_valid_i;
endmodule

// File: tb/scr_pair_tb.sv
module scr_pair_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poly_sel = 1'b0, mode = 1'b0;
  logic tx_valid = 1'b0, tx_data = 1'b0, tx_frame = 1'b0;
  logic rx_valid = 1'b0, rx_line = 1'b0, rx_frame = 1'b0;
  logic tx_valid_o, tx_line_o, rx_valid_o, rx_data_o;

  int n_chk = 0, n_bad = 0;
  logic cur_poly = 1'b0, cur_mode = 1'b0;
  logic [22:0] tm, rm;
  logic [1:0] pcfg;
  logic last_line, last_rx;

  always #4 clk = ~clk;

  scr_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .poly_sel_i(poly_sel), .mode_i(mode),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_frame_i(tx_frame),
    .tx_valid_o(tx_valid_o), .tx_line_o(tx_line_o),
    .rx_valid_i(rx_valid), .rx_line_i(rx_line), .rx_frame_i(rx_frame),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic mfb(input logic [22:0] s, input logic p);
    return p ? (s[22] ^ s[17]) : (s[6] ^ s[5]);
  endfunction

  // reference step for one side, from R2/R3/R6/R7/R8/R9/R10
  task automatic mstep(inout logic [22:0] s, input logic v, input logic in,
                       input logic fr, input logic descr, input logic chg,
                       output logic o);
    logic [22:0] e;
    logic f;
    e = (chg || (cur_mode && fr)) ? '1 : s;
    f = mfb(e, cur_poly);
    o = in ^ f;
    if (v) s = {e[21:0], cur_mode ? f : (descr ? in : o)};
    else if (chg) s = '1;
  endtask

  // one looped-back valid bit with optional line error
  task automatic lb(input logic d, input logic tf, input logic rf,
                    input logic err, input string tag);
    logic chg, et, er;
    @(negedge clk);
    poly_sel = cur_poly; mode = cur_mode;
    tx_valid = 1'b1; tx_data = d; tx_frame = tf;
    rx_valid = 1'b1; rx_frame = rf;
    #1;
    rx_line = tx_line_o ^ err;
    #1;
    chg = ({cur_poly, cur_mode} != pcfg);
    mstep(tm, 1'b1, d, tf, 1'b0, chg, et);
    mstep(rm, 1'b1, rx_line, rf, 1'b1, chg, er);
    pcfg = {cur_poly, cur_mode};
    check(tag, tx_line_o, et);
    check(tag, rx_data_o, er);
    last_line = tx_line_o;
    last_rx = rx_data_o;
  endtask

  task automatic idle(input string tag);
    logic chg, et, er;
    @(negedge clk);
    poly_sel = cur_poly; mode = cur_mode;
    tx_valid = 1'b0; rx_valid = 1'b0; tx_frame = 1'b1; rx_frame = 1'b1;
    tx_data = 1'b1; rx_line = 1'b1;
    #2;
    chg = ({cur_poly, cur_mode} != pcfg);
    mstep(tm, 1'b0, 1'b1, 1'b1, 1'b0, chg, et);
    mstep(rm, 1'b0, 1'b1, 1'b1, 1'b1, chg, er);
    pcfg = {cur_poly, cur_mode};
    check(tag, tx_valid_o, 1'b0);
    check(tag, rx_valid_o, 1'b0);
  endtask

  function automatic logic pat(input int kind, input int i);
    case (kind)
      0: return 1'b0;
      1: return 1'b1;
      2: return i[0];
      default: return ((i * 13 + i / 3) % 7) < 3;
    endcase
  endfunction

  task automatic t_reset();
    cur_poly = 1'b0; cur_mode = 1'b0;
    for (int i = 0; i < 7; i++) begin
      lb(1'b0, 1'b0, 1'b0, 1'b0, "R1");
      check("R1", last_line, (i == 6));
    end
  endtask

  task automatic t_mult_patterns();
    cur_mode = 1'b0;
    for (int p = 0; p < 2; p++) begin
      cur_poly = p[0];
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 40; i++) begin
          lb(pat(k, i), 1'b0, 1'b0, 1'b0, "R3");
          check(p ? "R4 poly1" : "R4 poly0", last_rx, pat(k, i));
        end
    end
  endtask

  task automatic t_err_mult();
    cur_mode = 1'b0;
    for (int p = 0; p < 2; p++) begin
      int a, b, cnt;
      logic bad;
      cur_poly = p[0];
      a = p ? 18 : 6;
      b = p ? 23 : 7;
      cnt = 0;
      for (int i = 0; i < 30; i++) lb(pat(3, i), 1'b0, 1'b0, 1'b0, "R5");
      for (int i = 0; i < 40; i++) begin
        lb(pat(3, i), 1'b0, 1'b0, (i == 5), "R5");
        bad = (last_rx != pat(3, i));
        if (bad) cnt++;
        check("R5 position", bad, (i == 5) || (i == 5 + a) || (i == 5 + b));
      end
      n_chk++;
      if (cnt != 3) begin
        n_bad++;
        $display("FAIL R5 errors actual=%0d expected=3", cnt);
      end
    end
  endtask

  task automatic t_additive();
    cur_mode = 1'b1;
    for (int p = 0; p < 2; p++) begin
      int cnt;
      cur_poly = p[0];
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
        lb(pat(3, i), (i == 0), (i == 0), (i == 10), "R6");
        if (last_rx != pat(3, i)) cnt++;
      end
      n_chk++;
      if (cnt != 1) begin
        n_bad++;
        $display("FAIL R6 errors actual=%0d expected=1", cnt);
      end
    end
  endtask

  task automatic t_frame();
    logic [15:0] ks1, ks2;
    cur_mode = 1'b1; cur_poly = 1'b1;
    for (int i = 0; i < 16; i++) begin
      lb(1'b0, (i == 0), (i == 0), 1'b0, "R7");
      ks1[i] = last_line;
    end
    for (int i = 0; i < 11; i++) lb(pat(2, i), 1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 16; i++) begin
      lb(1'b0, (i == 0), (i == 0), 1'b0, "R7");
      ks2[i] = last_line;
    end
    for (int i = 0; i < 16; i++) check("R7 keystream repeat", ks2[i], ks1[i]);
  endtask

  task automatic t_frame_mult();
    cur_mode = 1'b0; cur_poly = 1'b0;
    for (int i = 0; i < 40; i++) begin
      lb(pat(3, i), (i % 5 == 2), (i % 7 == 3), 1'b0, "R8");
      check("R8 loopback", last_rx, pat(3, i));
    end
  endtask

  task automatic t_cfg();
    logic [15:0] ref_ks, got_ks;
    cur_mode = 1'b1; cur_poly = 1'b1;
    for (int i = 0; i < 16; i++) begin
      lb(1'b0, (i == 0), (i == 0), 1'b0, "R9");
      ref_ks[i] = last_line;
    end
    cur_poly = 1'b0;
    for (int i = 0; i < 9; i++) lb(pat(3, i), 1'b0, 1'b0, 1'b0, "R9");
    cur_poly = 1'b1;
    for (int i = 0; i < 16; i++) begin
      lb(1'b0, 1'b0, 1'b0, 1'b0, "R9");
      got_ks[i] = last_line;
    end
    for (int i = 0; i < 16; i++) check("R9 reseed on change", got_ks[i], ref_ks[i]);
    cur_mode = 1'b0;
    for (int i = 0; i < 10; i++) begin
      lb(pat(2, i), 1'b0, 1'b0, 1'b0, "R9");
      check("R9 loopback", last_rx, pat(2, i));
    end
  endtask

  task automatic t_valid();
    for (int m = 0; m < 2; m++) begin
      cur_mode = m[0]; cur_poly = 1'b0;
      for (int i = 0; i < 30; i++) begin
        if (i % 3 == 1) idle("R10");
        lb(pat(3, i), (m == 1 && i == 0), (m == 1 && i == 0), 1'b0, "R10");
        check("R10 loopback", last_rx, pat(3, i));
        check("R10 valid", tx_valid_o && rx_valid_o, 1'b1);
      end
      cur_poly = 1'b1;
      idle("R10");
      lb(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tm = '1; rm = '1; pcfg = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mult_patterns();
    t_err_mult();
    t_additive();
    t_frame();
    t_frame_mult();
    t_cfg();
    t_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule